// File: doc/BRIEF.md
# Drift-Compensated Nanosecond Time Counter

This block keeps a 64-bit time-of-day value counted in nanoseconds. A 32-bit fractional phase accumulator adds a programmable addend on every reference clock; each time that sum wraps past 2^32, the time value grows by a programmable nominal period. The addend is a fine frequency trim: a slightly larger or smaller addend makes the carries, and so the time steps, come a little more or less often. A bypass mode skips the accumulator and steps the time value by the period on every clock.

Software reaches the block through a simple 32-bit word-addressed register port. It sees a control word, the addend, the read-only accumulator and the two halves of the time value. A read of the low half captures the high half, so a low-then-high read pair is coherent. A write of the low half is staged and the whole 64-bit value loads when the high half is written. The live time value is also driven out on a wide port for local consumers.

Top module: `ns_time_counter`

## Requirements
- R1: After reset the control word, addend, accumulator and time value all read zero, and `tod_ns` is zero.
- R2: While the enable bit (control bit 2) is clear, the time value and the accumulator hold their values.
- R3: With enable set and bypass clear, the accumulator becomes (accumulator + addend) mod 2^32 on every clock, and the time value grows by the period field only on a clock where that sum carries out of bit 31.
- R4: With enable and bypass (control bit 3) both set, the time value grows by the period field on every clock and the accumulator holds.
- R5: While the soft reset bit (control bit 5) is set, the time value and the accumulator are forced to zero one clock later and stay zero; counting resumes one clock after the bit is cleared.
- R6: Reading word 3 returns the live low half and captures the high half; reading word 4 returns that captured high half, even if the time value changed in between.
- R7: A write to word 3 does not change the time value; a later write to word 4 loads {word 4 data, staged word 3 data} into the time value on that clock edge.
- R8: A time-set write to word 4 takes priority over an increment on the same clock, and a later increment carries from the low half into the high half.
- R9: The period is the 10-bit field at control bits 25:16; the control word (word 0) reads back bits 25:16, 5, 3 and 2 as written and zero elsewhere.
- R10: The accumulator (word 2) is read-only: a write to it has no effect; the addend is word 1 and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also the register port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (captures the high half on a word 3 read) |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, valid in the cycle of the strobe |
| tod_ns | output | 64 | Live time value in nanoseconds |

## Verification
The hardest situation to reach is the same-cycle clash of a time-set and an increment, because the increment in normal mode only fires on an accumulator carry whose cycle depends on the addend history. The stimulus sidesteps the guesswork by switching to bypass mode, where every clock increments, and then issuing the staged low write and the high write. It picks a low half just under the wrap so the next increment must carry into the high half. The carry cadence of normal mode is made exact by an addend of one quarter of 2^32 starting from a cleared accumulator, giving a period step on every fourth clock.

// File: rtl/nstc_pkg.sv
package nstc_pkg;
    localparam int BUS_W  = 32;
    localparam int TIME_W = 2 * BUS_W;
    localparam int PER_W  = 10;
    localparam int ADDR_W = 3;

    localparam int CTRL_EN_BIT   = 2;
    localparam int CTRL_BYP_BIT  = 3;
    localparam int CTRL_SRST_BIT = 5;
    localparam int CTRL_PER_LSB  = 16;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL    = 3'd0,
        REG_ADDEND  = 3'd1,
        REG_ACCUM   = 3'd2,
        REG_TIME_LO = 3'd3,
        REG_TIME_HI = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [PER_W-1:0] period;
        logic             srst;
        logic             bypass;
        logic             enable;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [BUS_W-1:0] w);
        ctrl_t c;
        c.period = w[CTRL_PER_LSB +: PER_W];
        c.srst   = w[CTRL_SRST_BIT];
        c.bypass = w[CTRL_BYP_BIT];
        c.enable = w[CTRL_EN_BIT];
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] ctrl_pack(input ctrl_t c);
        logic [BUS_W-1:0] w;
        w = '0;
        w[CTRL_PER_LSB +: PER_W] = c.period;
        w[CTRL_SRST_BIT]         = c.srst;
        w[CTRL_BYP_BIT]          = c.bypass;
        w[CTRL_EN_BIT]           = c.enable;
        return w;
    endfunction
endpackage

// File: rtl/nstc_phase_acc.sv
module nstc_phase_acc #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    input  logic         clear,
    input  logic [W-1:0] addend,
    output logic [W-1:0] acc,
    output logic         carry
);
    typedef struct packed {
        logic [W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [W:0] sum;

    always_comb begin
        st_d  = st_q;
        sum   = {1'b0, st_q.acc} + {1'b0, addend};
        carry = 1'b0;
        if (clear) begin
            st_d.acc = '0;
        end else if (step_en) begin
            st_d.acc = sum[W-1:0];
            carry    = sum[W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc = st_q.acc;
endmodule

// File: rtl/nstc_time_core.sv
module nstc_time_core #(
    parameter int TW = 64,
    parameter int PW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          set_stb,
    input  logic [TW-1:0] set_val,
    input  logic          adv,
    input  logic [PW-1:0] period,
    output logic [TW-1:0] tod
);
    localparam int PAD_W = TW - PW;

    typedef struct packed {
        logic [TW-1:0] tod;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear)        st_d.tod = '0;
        else if (set_stb) st_d.tod = set_val;
        else if (adv)     st_d.tod = st_q.tod + {{PAD_W{1'b0}}, period};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tod = st_q.tod;
endmodule

// File: rtl/nstc_regs.sv
module nstc_regs
    import nstc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [TIME_W-1:0] tod_ns,
    input  logic [BUS_W-1:0]  acc_val,
    output ctrl_t             ctrl,
    output logic [BUS_W-1:0]  addend,
    output logic              set_stb,
    output logic [TIME_W-1:0] set_val,
    output logic [BUS_W-1:0]  bus_rdata
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [BUS_W-1:0] addend;
        logic [BUS_W-1:0] lo_stage;
        logic [BUS_W-1:0] hi_snap;
    } reg_state_t;

    reg_state_t st_d, st_q;
    reg_sel_e   sel;

    assign sel = reg_sel_e'(bus_addr);

    always_comb begin
        st_d    = st_q;
        set_stb = 1'b0;
        set_val = {bus_wdata, st_q.lo_stage};
        if (bus_wr) begin
            case (sel)
                REG_CTRL:    st_d.ctrl     = ctrl_unpack(bus_wdata);
                REG_ADDEND:  st_d.addend   = bus_wdata;
                REG_TIME_LO: st_d.lo_stage = bus_wdata;
                REG_TIME_HI: set_stb       = 1'b1;
                default:     ;
            endcase
        end
        if (bus_rd && sel == REG_TIME_LO) begin
            st_d.hi_snap = tod_ns[TIME_W-1:BUS_W];
        end
    end

    always_comb begin
        case (sel)
            REG_CTRL:    bus_rdata = ctrl_pack(st_q.ctrl);
            REG_ADDEND:  bus_rdata = st_q.addend;
            REG_ACCUM:   bus_rdata = acc_val;
            REG_TIME_LO: bus_rdata = tod_ns[BUS_W-1:0];
            REG_TIME_HI: bus_rdata = st_q.hi_snap;
            default:     bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl   = st_q.ctrl;
    assign addend = st_q.addend;
endmodule

// File: rtl/ns_time_counter.sv
module ns_time_counter
    import nstc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [TIME_W-1:0] tod_ns
);
    ctrl_t             ctrl_w;
    logic [BUS_W-1:0]  addend_w;
    logic [BUS_W-1:0]  acc_w;
    logic              carry_w;
    logic              set_stb_w;
    logic [TIME_W-1:0] set_val_w;
    logic              step_w;
    logic              adv_w;

    // Accumulator steps only in trimmed mode; the time value advances on
    // every clock in bypass mode, otherwise on an accumulator carry.
    assign step_w = ctrl_w.enable & ~ctrl_w.bypass;
    assign adv_w  = ctrl_w.enable & (ctrl_w.bypass | carry_w);

    nstc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .tod_ns    (tod_ns),
        .acc_val   (acc_w),
        .ctrl      (ctrl_w),
        .addend    (addend_w),
        .set_stb   (set_stb_w),
        .set_val   (set_val_w),
        .bus_rdata (bus_rdata)
    );

    nstc_phase_acc #(.W(BUS_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (step_w),
        .clear   (ctrl_w.srst),
        .addend  (addend_w),
        .acc     (acc_w),
        .carry   (carry_w)
    );

    nstc_time_core #(.TW(TIME_W), .PW(PER_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ctrl_w.srst),
        .set_stb (set_stb_w),
        .set_val (set_val_w),
        .adv     (adv_w),
        .period  (ctrl_w.period),
        .tod     (tod_ns)
    );
endmodule

// File: rtl/nstc_checker.sv
module nstc_checker
    import nstc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [TIME_W-1:0] tod_ns,
    input logic [BUS_W-1:0]  acc,
    input logic [BUS_W-1:0]  addend,
    input ctrl_t             ctrl
);
    logic hi_wr;
    assign hi_wr = bus_wr && (bus_addr == REG_TIME_HI);

    a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.enable && !ctrl.srst && !hi_wr) |=> ($stable(tod_ns) && $stable(acc)));

    a_r3_acc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.enable && !ctrl.bypass && !ctrl.srst) |=> (acc == $past(acc) + $past(addend)));

    a_r4_bypass_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.enable && ctrl.bypass && !ctrl.srst && !hi_wr)
        |=> (tod_ns == $past(tod_ns) + TIME_W'($past(ctrl.period)) && $stable(acc)));

    a_r5_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.srst |=> (tod_ns == '0 && acc == '0));

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr && !ctrl.srst) |=> (tod_ns[TIME_W-1:BUS_W] == $past(bus_wdata)));
endmodule

bind ns_time_counter nstc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tod_ns    (tod_ns),
    .acc       (acc_w),
    .addend    (addend_w),
    .ctrl      (ctrl_w)
);

// File: tb/sim_ns_time_counter.sv
module sim_ns_time_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] tod_ns;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    ns_time_counter u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tod_ns    (tod_ns)
    );

    // Monitor: compares read data against the scoreboard in the read cycle.
    always @(negedge clk) begin
        if (bus_rd) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL scoreboard empty: act=%h exp=none", bus_rdata);
            end else begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    bad++;
                    $display("FAIL %s read: act=%h exp=%h", t, bus_rdata, e);
                end
            end
        end
    end

    // All tasks start and end 2 ns after a rising edge.
    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #2;
        bus_rd = 1'b0;
    endtask

    task automatic chk_tod(input logic [63:0] e, input string t);
        total++;
        if (tod_ns !== e) begin
            bad++;
            $display("FAIL %s tod: act=%h exp=%h", t, tod_ns, e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired: act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] t0;
        logic [63:0] tb;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk_tod(64'h0, "R1");
        rd(3'd0, 32'h0, "R1");
        rd(3'd1, 32'h0, "R1");
        rd(3'd2, 32'h0, "R1");
        rd(3'd3, 32'h0, "R1");
        rd(3'd4, 32'h0, "R1");

        // R7 staged low write, load on high write
        wr(3'd3, 32'h1111_2222);
        chk_tod(64'h0, "R7");
        wr(3'd4, 32'h0000_0005);
        chk_tod(64'h0000_0005_1111_2222, "R7");

        // R6 coherent read: snapshot survives a time change
        rd(3'd3, 32'h1111_2222, "R6");
        wr(3'd3, 32'hAAAA_0000);
        wr(3'd4, 32'h0000_0009);
        rd(3'd4, 32'h0000_0005, "R6");
        rd(3'd3, 32'hAAAA_0000, "R6");
        rd(3'd4, 32'h0000_0009, "R6");

        // R10 addend readback; R2 disabled holds
        wr(3'd1, 32'h4000_0000);
        rd(3'd1, 32'h4000_0000, "R10");
        wr(3'd0, 32'h0007_0000);
        idle(5);
        t0 = 64'h0000_0009_AAAA_0000;
        chk_tod(t0, "R2");
        rd(3'd2, 32'h0, "R2");

        // R3 carry every fourth clock with addend 2^30, period 7
        wr(3'd0, 32'h0007_0004);
        chk_tod(t0, "R3");
        idle(3);
        chk_tod(t0, "R3");
        idle(1);
        chk_tod(t0 + 64'd7, "R3");
        idle(4);
        chk_tod(t0 + 64'd14, "R3");
        idle(1);
        rd(3'd2, 32'h4000_0000, "R3");
        wr(3'd0, 32'h0007_0000);
        idle(3);
        chk_tod(t0 + 64'd14, "R2");
        rd(3'd2, 32'hC000_0000, "R2");

        // R10 accumulator write ignored
        wr(3'd2, 32'h0000_1234);
        rd(3'd2, 32'hC000_0000, "R10");

        // R4 bypass every clock; R8 set beats increment, carry into high half
        tb = t0 + 64'd14;
        wr(3'd0, 32'h0003_000C);
        chk_tod(tb, "R4");
        idle(2);
        chk_tod(tb + 64'd6, "R4");
        rd(3'd2, 32'hC000_0000, "R4");
        wr(3'd3, 32'hFFFF_FFFE);
        wr(3'd4, 32'h0000_0020);
        chk_tod(64'h0000_0020_FFFF_FFFE, "R8");
        idle(1);
        chk_tod(64'h0000_0021_0000_0001, "R8");

        // R5 soft reset clears and holds, resumes after clearing
        wr(3'd0, 32'h0003_002C);
        idle(1);
        chk_tod(64'h0, "R5");
        rd(3'd2, 32'h0, "R5");
        idle(2);
        chk_tod(64'h0, "R5");
        wr(3'd0, 32'h0003_000C);
        chk_tod(64'h0, "R5");
        idle(1);
        chk_tod(64'd3, "R5");

        // R9 control readback mask and full-width period
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, 32'h03FF_002C, "R9");
        wr(3'd0, 32'h03FF_000C);
        chk_tod(64'h0, "R9");
        idle(1);
        chk_tod(64'd1023, "R9");
        idle(1);
        chk_tod(64'd2046, "R9");

        idle(2);
        if (exp_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL scoreboard leftover: act=%0d exp=0", exp_q.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule